// File: doc/BRIEF.md
# GPIO port controller

This block controls one port of sixteen general-purpose I/O pins through a small synchronous register bus. A set of per-pin configuration fields picks, for each pin, one of four operating modes, a drive type, a pull resistor choice, a slew code and a peripheral source. The block turns those fields into registered pad-side control signals: drive value, output enable, open-drain flag, pull-up and pull-down enables, speed code and input-buffer enable.

The pin levels come back through a two-flop synchronizer and are stored in an input data register that software reads over the same bus. Output data can be written whole, or changed atomically through a set/clear register. With that register, one bus write raises some pins and lowers others, and no read-modify-write sequence is needed.

Word offsets on the bus: 0 mode (2 bits per pin, pin p at bits 2p+1:2p), 1 output type (bit p), 2 speed (2 bits per pin), 3 pull (2 bits per pin), 4 input data (read-only), 5 output data, 6 set/clear (write-only), 7 peripheral selectors for pins 0 to 7 (4 bits per pin, pin p at bits 4p+3:4p), 8 peripheral selectors for pins 8 to 15 (pin p at bits 4(p-8)+3:4(p-8)).

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin is in input mode, floating, at speed code 00, push-pull, with peripheral selector 0 and output data 0. The pads show pad_oe=0, pad_ie=1, pad_pu=0, pad_pd=0 and pad_out=0, and bus_rdata is 0.
- R2: The mode codes are 00 input, 01 output, 10 peripheral and 11 analog. In input mode the pin has pad_oe=0, pad_out=0 and pad_ie=1.
- R3: In output mode with type bit 0 (push-pull), pad_oe=1 and pad_out equals the pin's output data bit.
- R4: In output or peripheral mode with type bit 1 (open-drain), pad_od=1 and pad_out=0. pad_oe is the inverse of the pin's value, so a value of 1 floats the pad.
- R5: In peripheral mode the pin's value is alt_src[sel], where sel is the pin's 4-bit selector at offset 7 (pins 0 to 7) or offset 8 (pins 8 to 15).
- R6: In analog mode pad_oe, pad_pu, pad_pd and pad_ie are all 0, and the pin's bit in the input data register reads 0.
- R7: Pull code 01 enables pad_pu and code 10 enables pad_pd. Codes 00 and 11 leave both off. The pull code acts in every mode except analog. pad_speed carries each pin's 2-bit speed code unchanged.
- R8: A write to offset 6 sets the output data bits flagged in bits 15:0 and clears the bits flagged in bits 31:16. Set wins when a pin is flagged in both halves. Unflagged bits keep their value. Offset 6 reads as 0.
- R9: A level on pad_in that is present before clock edge n is stored in the input data register at edge n+2. A read strobe (bus_sel=1, bus_wr=0) returns the addressed register on bus_rdata at the next edge. bus_rdata is 0 after any cycle without a read strobe.
- R10: The pad signals are registered. A configuration written at edge n shows on the pads from edge n+1.
- R11: Writes to offset 4 and to unused offsets change no state, and reads of unused offsets return 0.
- R12: The configuration registers at offsets 0, 1, 2, 3, 5, 7 and 8 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| pad_in | input | NPIN | Pin levels from the pads |
| alt_src | input | NALT | Peripheral output signals |
| pad_out | output | NPIN | Drive value per pin |
| pad_oe | output | NPIN | Output enable per pin |
| pad_od | output | NPIN | Open-drain flag per pin |
| pad_pu | output | NPIN | Pull-up enable per pin |
| pad_pd | output | NPIN | Pull-down enable per pin |
| pad_ie | output | NPIN | Input-buffer enable per pin |
| pad_speed | output | 2*NPIN | Slew code per pin |

## Verification
The assertions assume a bus that drives bus_sel, bus_wr, bus_addr and bus_wdata to known values on every clock edge once reset is released. They also assume pad_in and alt_src are never unknown. The bench drives every input from reset onward, and it changes them only at the falling edge, so each value is stable at the rising edge that samples it. It keeps the read strobe low except during a read, which makes the zero-when-idle property of bus_rdata hold. It writes the set/clear register with overlapping set and clear masks on purpose, so that the priority property is exercised.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  localparam int OFF_MODE   = 0;
  localparam int OFF_TYPE   = 1;
  localparam int OFF_SPEED  = 2;
  localparam int OFF_PULL   = 3;
  localparam int OFF_IDR    = 4;
  localparam int OFF_ODR    = 5;
  localparam int OFF_SETCLR = 6;
  localparam int OFF_AFLO   = 7;
  localparam int OFF_AFHI   = 8;

  localparam int HALF_W = 16;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int NPIN   = 16,
  parameter int AF_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NPIN-1:0]      sync_in,
  output logic [2*NPIN-1:0]    mode_o,
  output logic [NPIN-1:0]      otype_o,
  output logic [2*NPIN-1:0]    speed_o,
  output logic [2*NPIN-1:0]    pull_o,
  output logic [NPIN-1:0]      odr_o,
  output logic [AF_W*NPIN-1:0] af_o
);
  localparam int AF_BITS = AF_W * NPIN;

  logic [2*NPIN-1:0]  mode_q, speed_q, pull_q;
  logic [NPIN-1:0]    otype_q, odr_q, idr_q, amask;
  logic [AF_BITS-1:0] af_q;
  logic [31:0]        rd_val;
  logic               wr_hit, rd_hit;

  assign wr_hit = bus_sel && bus_wr;
  assign rd_hit = bus_sel && !bus_wr;

  for (genvar p = 0; p < NPIN; p++) begin : g_amask
    assign amask[p] = (mode_q[2*p +: 2] == PM_ANA);
  end

  always_comb begin
    case (32'(bus_addr))
      OFF_MODE:  rd_val = 32'(mode_q);
      OFF_TYPE:  rd_val = 32'(otype_q);
      OFF_SPEED: rd_val = 32'(speed_q);
      OFF_PULL:  rd_val = 32'(pull_q);
      OFF_IDR:   rd_val = 32'(idr_q);
      OFF_ODR:   rd_val = 32'(odr_q);
      OFF_AFLO:  rd_val = af_q[31:0];
      OFF_AFHI:  rd_val = 32'(af_q[AF_BITS-1:32]);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      otype_q   <= '0;
      speed_q   <= '0;
      pull_q    <= '0;
      odr_q     <= '0;
      idr_q     <= '0;
      af_q      <= '0;
      bus_rdata <= '0;
    end else begin
      idr_q     <= sync_in & ~amask;
      bus_rdata <= rd_hit ? rd_val : '0;
      if (wr_hit) begin
        case (32'(bus_addr))
          OFF_MODE:   mode_q  <= bus_wdata[2*NPIN-1:0];
          OFF_TYPE:   otype_q <= bus_wdata[NPIN-1:0];
          OFF_SPEED:  speed_q <= bus_wdata[2*NPIN-1:0];
          OFF_PULL:   pull_q  <= bus_wdata[2*NPIN-1:0];
          OFF_ODR:    odr_q   <= bus_wdata[NPIN-1:0];
          OFF_SETCLR: odr_q   <= (odr_q & ~bus_wdata[HALF_W +: NPIN]) | bus_wdata[NPIN-1:0];
          OFF_AFLO:   af_q[31:0] <= bus_wdata;
          OFF_AFHI:   af_q[AF_BITS-1:32] <= bus_wdata[AF_BITS-33:0];
          default: ;
        endcase
      end
    end
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign speed_o = speed_q;
  assign pull_o  = pull_q;
  assign odr_o   = odr_q;
  assign af_o    = af_q;

  // R8: every flagged set bit is high after the write
  p_setclr_set_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && 32'(bus_addr) == OFF_SETCLR) |=>
      ((odr_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  // R8: bits flagged in neither half keep their value
  p_setclr_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && 32'(bus_addr) == OFF_SETCLR) |=>
      (((odr_q ^ $past(odr_q)) &
        ~($past(bus_wdata[NPIN-1:0]) | $past(bus_wdata[HALF_W +: NPIN]))) == '0));

  // R6: analog pins never store a one in input data
  p_analog_idr_r6: assert property (@(posedge clk) disable iff (rst)
    (amask != '0) |=> ((idr_q & $past(amask)) == '0));

  // R9: read data is zero after a cycle without a read strobe
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (bus_rdata == '0));
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_port_pkg::*;
#(
  parameter int NALT = 16,
  parameter int AF_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode,
  input  logic            otype,
  input  logic [1:0]      speed,
  input  logic [1:0]      pull,
  input  logic            odr_bit,
  input  logic [AF_W-1:0] af_sel,
  input  logic [NALT-1:0] alt_src,
  output logic            pad_out,
  output logic            pad_oe,
  output logic            pad_od,
  output logic            pad_pu,
  output logic            pad_pd,
  output logic            pad_ie,
  output logic [1:0]      pad_speed
);
  localparam int SELN = 2 ** AF_W;

  logic [SELN-1:0] alt_ext;
  logic            drive, analog, val;

  assign alt_ext = SELN'(alt_src);
  assign drive   = (mode == PM_OUT) || (mode == PM_ALT);
  assign analog  = (mode == PM_ANA);
  assign val     = (mode == PM_ALT) ? alt_ext[af_sel] : odr_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out   <= 1'b0;
      pad_oe    <= 1'b0;
      pad_od    <= 1'b0;
      pad_pu    <= 1'b0;
      pad_pd    <= 1'b0;
      pad_ie    <= 1'b1;
      pad_speed <= '0;
    end else begin
      pad_out   <= drive && !otype && val;
      pad_oe    <= drive && !(otype && val);
      pad_od    <= drive && otype;
      pad_pu    <= !analog && (pull == 2'b01);
      pad_pd    <= !analog && (pull == 2'b10);
      pad_ie    <= !analog;
      pad_speed <= speed;
    end
  end

  // R6: analog pin is fully quiet on the next cycle
  p_analog_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_ANA) |=> (!pad_oe && !pad_pu && !pad_pd && !pad_ie));

  // R2: input mode never drives the pad
  p_input_hiz_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_IN) |=> (!pad_oe && !pad_out && pad_ie));

  // R4: open-drain with a high value releases the pad
  p_od_float_r4: assert property (@(posedge clk) disable iff (rst)
    (drive && otype && val) |=> (!pad_oe && pad_od));

  // R7: both pulls are never on together
  p_pull_excl_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> !(pad_pu && pad_pd));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NPIN   = 16,
  parameter int NALT   = 16,
  parameter int AF_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  input  logic [NALT-1:0]   alt_src,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_od,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_pd,
  output logic [NPIN-1:0]   pad_ie,
  output logic [2*NPIN-1:0] pad_speed
);
  logic [NPIN-1:0]      sync_lvl;
  logic [2*NPIN-1:0]    mode_w, speed_w, pull_w;
  logic [NPIN-1:0]      otype_w, odr_w;
  logic [AF_W*NPIN-1:0] af_w;

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_lvl)
  );

  gpio_cfg_regs #(.NPIN(NPIN), .AF_W(AF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sync_in   (sync_lvl),
    .mode_o    (mode_w),
    .otype_o   (otype_w),
    .speed_o   (speed_w),
    .pull_o    (pull_w),
    .odr_o     (odr_w),
    .af_o      (af_w)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    gpio_pin_slice #(.NALT(NALT), .AF_W(AF_W)) u_pin (
      .clk       (clk),
      .rst       (rst),
      .mode      (mode_w[2*p +: 2]),
      .otype     (otype_w[p]),
      .speed     (speed_w[2*p +: 2]),
      .pull      (pull_w[2*p +: 2]),
      .odr_bit   (odr_w[p]),
      .af_sel    (af_w[AF_W*p +: AF_W]),
      .alt_src   (alt_src),
      .pad_out   (pad_out[p]),
      .pad_oe    (pad_oe[p]),
      .pad_od    (pad_od[p]),
      .pad_pu    (pad_pu[p]),
      .pad_pd    (pad_pd[p]),
      .pad_ie    (pad_ie[p]),
      .pad_speed (pad_speed[2*p +: 2])
    );
  end
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0, alt_src = '0;
  logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_ie;
  logic [31:0] pad_speed;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .alt_src(alt_src),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_ie(pad_ie), .pad_speed(pad_speed)
  );

  // Behavioural reference model, updated on each rising edge
  logic [31:0] m_mode, m_speed, m_pull, m_rdata, m_spd;
  logic [15:0] m_type, m_odr, m_s1, m_s2, m_idr;
  logic [63:0] m_af;
  logic [15:0] m_out, m_oe, m_od, m_pu, m_pd, m_ie;

  always @(posedge clk) begin : model
    logic [1:0] md, pl;
    logic v, drv;
    logic [15:0] amk;
    logic [31:0] rv;
    if (rst) begin
      m_mode <= 0; m_speed <= 0; m_pull <= 0; m_type <= 0; m_odr <= 0; m_af <= 0;
      m_s1 <= 0; m_s2 <= 0; m_idr <= 0; m_rdata <= 0;
      m_out <= 0; m_oe <= 0; m_od <= 0; m_pu <= 0; m_pd <= 0; m_ie <= '1; m_spd <= 0;
    end else begin
      amk = 0;
      for (int p = 0; p < 16; p++) begin
        md = m_mode[2*p +: 2];
        pl = m_pull[2*p +: 2];
        drv = (md == 2'b01) || (md == 2'b10);
        v = (md == 2'b10) ? alt_src[m_af[4*p +: 4]] : m_odr[p];
        amk[p] = (md == 2'b11);
        m_out[p] <= drv && !m_type[p] && v;
        m_oe[p]  <= drv && !(m_type[p] && v);
        m_od[p]  <= drv && m_type[p];
        m_pu[p]  <= (md != 2'b11) && (pl == 2'b01);
        m_pd[p]  <= (md != 2'b11) && (pl == 2'b10);
        m_ie[p]  <= (md != 2'b11);
      end
      m_spd <= m_speed;
      m_s1 <= pad_in; m_s2 <= m_s1; m_idr <= m_s2 & ~amk;
      case (bus_addr)
        0: rv = m_mode;  1: rv = {16'h0, m_type}; 2: rv = m_speed; 3: rv = m_pull;
        4: rv = {16'h0, m_idr}; 5: rv = {16'h0, m_odr};
        7: rv = m_af[31:0]; 8: rv = m_af[63:32];
        default: rv = 0;
      endcase
      m_rdata <= (bus_sel && !bus_wr) ? rv : 0;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          0: m_mode <= bus_wdata; 1: m_type <= bus_wdata[15:0];
          2: m_speed <= bus_wdata; 3: m_pull <= bus_wdata;
          5: m_odr <= bus_wdata[15:0];
          6: for (int p = 0; p < 16; p++)
               if (bus_wdata[p]) m_odr[p] <= 1'b1;
               else if (bus_wdata[16+p]) m_odr[p] <= 1'b0;
          7: m_af[31:0] <= bus_wdata; 8: m_af[63:32] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 rdata", bus_rdata, m_rdata);
      chk("R3 pad_out", {16'h0, pad_out}, {16'h0, m_out});
      chk("R2 pad_oe", {16'h0, pad_oe}, {16'h0, m_oe});
      chk("R4 pad_od", {16'h0, pad_od}, {16'h0, m_od});
      chk("R7 pad_pu/pd", {pad_pu, pad_pd}, {m_pu, m_pd});
      chk("R6 pad_ie", {16'h0, pad_ie}, {16'h0, m_ie});
      chk("R7 pad_speed", pad_speed, m_spd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(4);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 pad_oe", {16'h0, pad_oe}, 0);
    chk("R1 pad_ie", {16'h0, pad_ie}, 32'h0000_FFFF);
    chk("R1 pulls", {pad_pu, pad_pd}, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(0, r); chk("R1 mode", r, 0);
    rd(5, r); chk("R1 odr", r, 0);

    // R9 synchronised input data
    pad_in = 16'hA5C3;
    idle(3);
    rd(4, r); chk("R9 idr", r, 32'h0000_A5C3);

    // R3 / R10 output mode
    wr(0, 32'h5555_5555);
    wr(5, 32'h0000_FFFF);
    idle(1);
    chk("R3 out all high", {16'h0, pad_out}, 32'h0000_FFFF);
    wr(5, 32'h0000_1234);
    chk("R10 pads still old", {16'h0, pad_out}, 32'h0000_FFFF);
    idle(1);
    chk("R3 out pattern", {16'h0, pad_out}, 32'h0000_1234);
    chk("R3 oe", {16'h0, pad_oe}, 32'h0000_FFFF);

    // R8 set/clear with overlap on pin 9
    wr(6, 32'h0204_0201);
    rd(5, r); chk("R8 odr after setclr", r, 32'h0000_1231);
    rd(6, r); chk("R8 setclr reads zero", r, 0);
    wr(6, 32'h0000_0000);
    rd(5, r); chk("R8 zero write keeps", r, 32'h0000_1231);

    // R4 open drain on pins 0..7
    wr(1, 32'h0000_00FF);
    idle(1);
    chk("R4 oe", {16'h0, pad_oe}, 32'h0000_FFCE);
    chk("R4 out", {16'h0, pad_out}, 32'h0000_1200);
    chk("R4 od", {16'h0, pad_od}, 32'h0000_00FF);

    // R5 peripheral mode
    wr(1, 0);
    wr(0, 32'hAAAA_AAAA);
    wr(7, 32'h7654_3210);
    wr(8, 32'hFEDC_BA98);
    alt_src = 16'h3C5A;
    idle(2);
    chk("R5 identity select", {16'h0, pad_out}, 32'h0000_3C5A);
    wr(7, 32'hFFFF_FFFF);
    wr(8, 32'hFFFF_FFFF);
    idle(1);
    chk("R5 all pick src15 low", {16'h0, pad_out}, 0);
    alt_src = 16'h8000;
    idle(2);
    chk("R5 all pick src15 high", {16'h0, pad_out}, 32'h0000_FFFF);
    rd(8, r); chk("R12 afhi readback", r, 32'hFFFF_FFFF);

    // R6 / R7 analog upper byte, pulls and speed
    wr(0, 32'hFFFF_0000);
    wr(3, 32'h5555_5555);
    pad_in = 16'hFFFF;
    idle(4);
    chk("R7 pull up", {pad_pu, pad_pd}, 32'h00FF_0000);
    chk("R6 ie", {16'h0, pad_ie}, 32'h0000_00FF);
    chk("R6 oe", {16'h0, pad_oe}, 0);
    rd(4, r); chk("R6 analog idr zero", r, 32'h0000_00FF);
    wr(3, 32'hAAAA_AAAA);
    idle(1);
    chk("R7 pull down", {pad_pu, pad_pd}, 32'h0000_00FF);
    wr(3, 32'hFFFF_FFFF);
    idle(1);
    chk("R7 reserved floats", {pad_pu, pad_pd}, 0);
    wr(2, 32'h1B1B_1B1B);
    idle(1);
    chk("R7 speed", pad_speed, 32'h1B1B_1B1B);
    rd(0, r); chk("R12 mode readback", r, 32'hFFFF_0000);
    rd(3, r); chk("R12 pull readback", r, 32'hFFFF_FFFF);

    // R11 ignored writes
    wr(4, 32'h0000_0000);
    rd(4, r); chk("R11 idr write ignored", r, 32'h0000_00FF);
    wr(15, 32'hDEAD_BEEF);
    rd(15, r); chk("R11 unused reads zero", r, 0);
    rd(5, r); chk("R11 odr untouched", r, 32'h0000_1231);

    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule